// File: doc/BRIEF.md
# Halt-Mode Power Sequencer

This block steers a small processor core into and out of its deepest stop state. A halt strobe from the core's decoder starts the sequence. Whether anything happens depends on two conditions. If the oscillator-interrupt status bit is set, the strobe is dropped. If the watchdog is running and its halt option asks for a reset, the block emits a one-cycle watchdog reset pulse and the core keeps running. In every other case the block stops the oscillator and gates the CPU and peripheral clocks. It also forces the two interrupt-mask bits to the enabled code, so a wake interrupt that is already pending ends the halt at once.

While halted, only the request lines selected by a wake mask parameter, or a reset request, end the stop state. On a wake the oscillator restarts at once. The CPU and peripheral clocks stay gated while a counter runs a stabilisation delay of 256 or 4096 cycles; a select input, sampled in the wake cycle, picks the length. After the delay the block raises a one-cycle resume indication. This indication tells the core whether to fetch the reset vector or to service the interrupt. Peripherals that run from an external clock can be kept alive by a separate input.

Top module: `hseq_top`

## Requirements
- R1: A halt strobe in the run state enters the halted state on the next clock edge only when oscIntEn is 0 and the watchdog-reset condition (wdgEnabled and wdgHaltReset both 1) is false. With oscIntEn at 1 the strobe changes no output.
- R2: A halt strobe in the run state with oscIntEn 0, wdgEnabled 1 and wdgHaltReset 1 raises wdgResetPulse for exactly one cycle, starting after the next edge. The CPU and peripheral clock enables stay at 1 throughout.
- R3: While halted, oscEn, cpuClkEn and periphClkEn are 0. extPeriphClkEn equals extClkRun while halted and is 1 whenever periphClkEn is 1.
- R4: While halted, maskForceEn is 1 and maskForceVal is binary 10 (bit 1 set, bit 0 clear). maskForceEn is 0 in every other state.
- R5: If a wake-capable request is already high on the first halted cycle, the block leaves halt on the following edge, so exactly one halted cycle occurs.
- R6: Request lines whose WAKE_MASK bit is 0 (lines 7..4 by default) have no effect while halted. The oscillator stays off.
- R7: From the wake edge, oscEn is 1 while cpuClkEn and periphClkEn stay 0 for exactly 256 cycles when longDelaySel was 0 in the wake cycle, or for 4096 cycles when it was 1. Changes to longDelaySel after the wake cycle have no effect.
- R8: After the delay, resumeValid is 1 for exactly one cycle, with the clocks already enabled. resumeIsReset is 1 for a reset wake and 0 for an interrupt wake. The block is then back in the run state.
- R9: When a reset request and a wake interrupt arrive in the same halted cycle, the reset wins and resumeIsReset is 1.
- R10: After reset the block is in the run state: oscEn, cpuClkEn and periphClkEn are 1, and wdgResetPulse, maskForceEn and resumeValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltStrobe | input | 1 | One-cycle halt instruction strobe |
| oscIntEn | input | 1 | Oscillator-interrupt status bit; 1 blocks halt |
| wdgEnabled | input | 1 | Watchdog is running |
| wdgHaltReset | input | 1 | Watchdog option: halt causes a reset |
| irqReq | input | NUM_IRQ | Interrupt request lines |
| resetReq | input | 1 | Reset request used as a wake source |
| longDelaySel | input | 1 | 1 selects the long stabilisation delay |
| extClkRun | input | 1 | Keep externally clocked peripherals running |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock gate enable |
| periphClkEn | output | 1 | Peripheral clock gate enable |
| extPeriphClkEn | output | 1 | Clock enable for externally clocked peripherals |
| wdgResetPulse | output | 1 | One-cycle watchdog reset |
| maskForceEn | output | 1 | Force interrupt-mask bits |
| maskForceVal | output | 2 | Value forced onto the mask bits |
| resumeValid | output | 1 | One-cycle resume indication |
| resumeIsReset | output | 1 | Resume cause: 1 reset vector, 0 interrupt |

## Verification
All gate and mask outputs decode the registered state, so they change in the cycle after the edge that samples the strobe or the wake. The watchdog pulse is a registered output, so it is also due one edge after the strobe. The stabilisation window is due D cycles after the wake edge, and resumeValid comes in the cycle after that. A behavioural model in the bench advances on each rising edge, using the inputs that were driven one nanosecond after the previous edge. Every output is compared against this model at the falling edge. Directed checks sample one nanosecond after an edge and count the gated cycles so that the 256/4096 window is confirmed exactly.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALTED = 2'd1,
    ST_STAB   = 2'd2,
    ST_RESUME = 2'd3
  } hseqState_e;

  typedef struct packed {
    logic captureWake;
    logic countEn;
  } hseqStrobe_t;

  localparam logic [1:0] MASK_OPEN = 2'b10;

endpackage

// File: rtl/hseq_dpath.sv
module hseq_dpath
  import hseq_pkg::*;
#(
  parameter int                 NUM_IRQ   = 8,
  parameter logic [NUM_IRQ-1:0] WAKE_MASK = 8'h0F,
  parameter int                 SHORT_DLY = 256,
  parameter int                 LONG_DLY  = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  hseqStrobe_t        strobe,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               resetReq,
  input  logic               longDelaySel,
  output logic               wakeSeen,
  output logic               stabDone,
  output logic               causeIsReset
);

  localparam int CNT_W = $clog2(LONG_DLY);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DLY - 1);

  logic [NUM_IRQ-1:0] wakeLines;
  logic [CNT_W-1:0]   stabCnt;
  logic               longLatched;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_wakeLine
    if (WAKE_MASK[i]) begin : g_on
      assign wakeLines[i] = irqReq[i];
    end else begin : g_off
      assign wakeLines[i] = 1'b0;
    end
  end

  assign wakeSeen = (|wakeLines) | resetReq;
  assign stabDone = strobe.countEn && (stabCnt == (longLatched ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt      <= '0;
      causeIsReset <= 1'b0;
      longLatched  <= 1'b0;
    end else if (strobe.captureWake) begin
      stabCnt      <= '0;
      causeIsReset <= resetReq;
      longLatched  <= longDelaySel;
    end else if (strobe.countEn) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureWake && resetReq) |=> causeIsReset); // R9

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureWake |=> (stabCnt == '0)); // R7

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !$past(strobe.captureWake)) |-> $stable(longLatched)); // R7

endmodule

// File: rtl/hseq_ctrl.sv
module hseq_ctrl
  import hseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltStrobe,
  input  logic        oscIntEn,
  input  logic        wdgEnabled,
  input  logic        wdgHaltReset,
  input  logic        wakeSeen,
  input  logic        stabDone,
  output hseqStrobe_t strobe,
  output logic        wdgResetPulse,
  output logic        oscEn,
  output logic        cpuClkEn,
  output logic        periphClkEn,
  output logic        maskForceEn,
  output logic        resumeValid
);

  hseqState_e state, stateNext;
  logic haltTaken, wdgTrip, wdgCond;

  assign wdgCond   = wdgEnabled && wdgHaltReset;
  assign haltTaken = (state == ST_RUN) && haltStrobe && !oscIntEn && !wdgCond;
  assign wdgTrip   = (state == ST_RUN) && haltStrobe && !oscIntEn && wdgCond;

  always_comb begin
    stateNext          = state;
    strobe.captureWake = 1'b0;
    strobe.countEn     = 1'b0;
    unique case (state)
      ST_RUN:    if (haltTaken) stateNext = ST_HALTED;
      ST_HALTED: if (wakeSeen) begin
                   stateNext          = ST_STAB;
                   strobe.captureWake = 1'b1;
                 end
      ST_STAB:   begin
                   strobe.countEn = 1'b1;
                   if (stabDone) stateNext = ST_RESUME;
                 end
      ST_RESUME: stateNext = ST_RUN;
      default:   stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_RUN;
      wdgResetPulse <= 1'b0;
    end else begin
      state         <= stateNext;
      wdgResetPulse <= wdgTrip;
    end
  end

  assign oscEn       = (state != ST_HALTED);
  assign cpuClkEn    = (state == ST_RUN) || (state == ST_RESUME);
  assign periphClkEn = cpuClkEn;
  assign maskForceEn = (state == ST_HALTED);
  assign resumeValid = (state == ST_RESUME);

  AST_OIE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && haltStrobe && oscIntEn) |=> (state == ST_RUN)); // R1

  AST_WDG_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && haltStrobe && !oscIntEn && wdgEnabled && wdgHaltReset)
      |=> (wdgResetPulse && cpuClkEn)); // R2

  AST_WDG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wdgResetPulse |=> !wdgResetPulse); // R2

  AST_PENDING_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALTED && wakeSeen) |=> (oscEn && !cpuClkEn)); // R5

  AST_RESUME_AFTER_STAB: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> ($past(state) == ST_STAB)); // R8

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> (!resumeValid && cpuClkEn)); // R8

endmodule

// File: rtl/hseq_top.sv
module hseq_top
  import hseq_pkg::*;
#(
  parameter int                 NUM_IRQ   = 8,
  parameter logic [NUM_IRQ-1:0] WAKE_MASK = 8'h0F,
  parameter int                 SHORT_DLY = 256,
  parameter int                 LONG_DLY  = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               haltStrobe,
  input  logic               oscIntEn,
  input  logic               wdgEnabled,
  input  logic               wdgHaltReset,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               resetReq,
  input  logic               longDelaySel,
  input  logic               extClkRun,
  output logic               oscEn,
  output logic               cpuClkEn,
  output logic               periphClkEn,
  output logic               extPeriphClkEn,
  output logic               wdgResetPulse,
  output logic               maskForceEn,
  output logic [1:0]         maskForceVal,
  output logic               resumeValid,
  output logic               resumeIsReset
);

  hseqStrobe_t strobe;
  logic wakeSeen, stabDone, causeIsReset;

  hseq_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .haltStrobe    (haltStrobe),
    .oscIntEn      (oscIntEn),
    .wdgEnabled    (wdgEnabled),
    .wdgHaltReset  (wdgHaltReset),
    .wakeSeen      (wakeSeen),
    .stabDone      (stabDone),
    .strobe        (strobe),
    .wdgResetPulse (wdgResetPulse),
    .oscEn         (oscEn),
    .cpuClkEn      (cpuClkEn),
    .periphClkEn   (periphClkEn),
    .maskForceEn   (maskForceEn),
    .resumeValid   (resumeValid)
  );

  hseq_dpath #(
    .NUM_IRQ   (NUM_IRQ),
    .WAKE_MASK (WAKE_MASK),
    .SHORT_DLY (SHORT_DLY),
    .LONG_DLY  (LONG_DLY)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .irqReq       (irqReq),
    .resetReq     (resetReq),
    .longDelaySel (longDelaySel),
    .wakeSeen     (wakeSeen),
    .stabDone     (stabDone),
    .causeIsReset (causeIsReset)
  );

  assign extPeriphClkEn = periphClkEn | extClkRun;
  assign maskForceVal   = maskForceEn ? MASK_OPEN : 2'b00;
  assign resumeIsReset  = resumeValid & causeIsReset;

  AST_MASK_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    maskForceEn |-> (maskForceVal == 2'b10 && !oscEn)); // R4

endmodule

// File: tb/tb_hseq_top.sv
`timescale 1ns/1ps
module tb_hseq_top;

  localparam int NIRQ = 8;
  localparam logic [NIRQ-1:0] WMASK = 8'h0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltStrobe = 0, oscIntEn = 0, wdgEnabled = 0, wdgHaltReset = 0;
  logic [NIRQ-1:0] irqReq = '0;
  logic resetReq = 0, longDelaySel = 0, extClkRun = 0;
  logic oscEn, cpuClkEn, periphClkEn, extPeriphClkEn, wdgResetPulse;
  logic maskForceEn, resumeValid, resumeIsReset;
  logic [1:0] maskForceVal;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hseq_top dut (
    .clk(clk), .rstN(rstN), .haltStrobe(haltStrobe), .oscIntEn(oscIntEn),
    .wdgEnabled(wdgEnabled), .wdgHaltReset(wdgHaltReset), .irqReq(irqReq),
    .resetReq(resetReq), .longDelaySel(longDelaySel), .extClkRun(extClkRun),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .extPeriphClkEn(extPeriphClkEn), .wdgResetPulse(wdgResetPulse),
    .maskForceEn(maskForceEn), .maskForceVal(maskForceVal),
    .resumeValid(resumeValid), .resumeIsReset(resumeIsReset)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 run, 1 halted, 2 stabilising, 3 resume
  int mState = 0, mCnt = 0, mLim = 256;
  bit mCause = 0, mWdg = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mCause = 0; mWdg = 0; mLim = 256;
    end else begin
      mWdg = (mState == 0) && haltStrobe && !oscIntEn && wdgEnabled && wdgHaltReset;
      case (mState)
        0: if (haltStrobe && !oscIntEn && !(wdgEnabled && wdgHaltReset)) mState = 1;
        1: if (((irqReq & WMASK) != 0) || resetReq) begin
             mState = 2; mCnt = 0; mCause = resetReq;
             mLim = longDelaySel ? 4096 : 256;
           end
        2: begin mCnt++; if (mCnt == mLim) mState = 3; end
        default: mState = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3 oscEn", oscEn, mState != 1);
      chk("R7 cpuClkEn", cpuClkEn, mState == 0 || mState == 3);
      chk("R7 periphClkEn", periphClkEn, mState == 0 || mState == 3);
      chk("R3 extPeriphClkEn", extPeriphClkEn, (mState == 0 || mState == 3) || extClkRun);
      chk("R2 wdgResetPulse", wdgResetPulse, mWdg);
      chk("R4 maskForceEn", maskForceEn, mState == 1);
      chk("R4 maskForceVal", maskForceVal, (mState == 1) ? 2 : 0);
      chk("R8 resumeValid", resumeValid, mState == 3);
      chk("R8 resumeIsReset", resumeIsReset, (mState == 3) && mCause);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enterHalt();
    haltStrobe = 1; cyc(1); haltStrobe = 0;
  endtask

  task automatic countGated(output int n);
    n = 0;
    while (!cpuClkEn && n < 5000) begin n++; cyc(1); end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    chk("R10 cpuClkEn", cpuClkEn, 1);
    chk("R10 oscEn", oscEn, 1);
    chk("R10 resumeValid", resumeValid, 0);
    chk("R10 maskForceEn", maskForceEn, 0);
    chk("R10 wdgResetPulse", wdgResetPulse, 0);
    rstN = 1; cyc(2);

    // R1: status bit blocks halt
    oscIntEn = 1; enterHalt();
    chk("R1 no halt cpuClkEn", cpuClkEn, 1);
    chk("R1 no halt oscEn", oscEn, 1);
    oscIntEn = 0; cyc(2);

    // R2: watchdog option turns halt into reset
    wdgEnabled = 1; wdgHaltReset = 1; enterHalt();
    chk("R2 pulse", wdgResetPulse, 1);
    chk("R2 clocks stay on", cpuClkEn, 1);
    cyc(1);
    chk("R2 pulse single", wdgResetPulse, 0);
    wdgHaltReset = 0; cyc(2);

    // R3/R4/R6/R7/R8: interrupt wake with short delay
    enterHalt();
    chk("R3 osc off", oscEn, 0);
    chk("R3 cpu off", cpuClkEn, 0);
    chk("R4 mask value", maskForceVal, 2);
    extClkRun = 1; cyc(1);
    chk("R3 ext periph runs", extPeriphClkEn, 1);
    irqReq = 8'hF0; cyc(40);
    chk("R6 masked lines ignored", oscEn, 0);
    irqReq = 8'h02; longDelaySel = 0; cyc(1);
    irqReq = '0; longDelaySel = 1;
    chk("R7 osc restarts", oscEn, 1);
    countGated(n);
    chk("R7 short window", n, 256);
    chk("R8 resume", resumeValid, 1);
    chk("R8 irq cause", resumeIsReset, 0);
    cyc(1);
    chk("R8 resume single", resumeValid, 0);
    extClkRun = 0; longDelaySel = 0; cyc(2);

    // R7/R8: reset wake with long delay
    enterHalt(); cyc(3);
    resetReq = 1; longDelaySel = 1; cyc(1);
    resetReq = 0; longDelaySel = 0;
    countGated(n);
    chk("R7 long window", n, 4096);
    chk("R8 reset cause", resumeIsReset, 1);
    cyc(2);

    // R5: pending wake interrupt exits after one halted cycle
    irqReq = 8'h01; enterHalt();
    chk("R5 halted once", oscEn, 0);
    cyc(1);
    chk("R5 left halt", oscEn, 1);
    chk("R5 clocks gated", cpuClkEn, 0);
    irqReq = '0;
    countGated(n);
    chk("R5 window", n, 256);
    cyc(2);

    // R9: simultaneous reset and interrupt
    enterHalt(); cyc(2);
    irqReq = 8'h04; resetReq = 1; cyc(1);
    irqReq = '0; resetReq = 0;
    countGated(n);
    chk("R9 reset wins", resumeIsReset, 1);
    cyc(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule